// File: doc/BRIEF.md
# UART FIFO Control and Receive Trigger

This block holds the write-only FIFO control register of a 16550-style UART together with the two byte queues that the register governs: one for receive and one for transmit. Software writes one byte to the register. That byte selects FIFO mode, flushes either queue, and picks a receive trigger level. The serial side pushes received bytes into the receive queue and pops bytes for transmission from the transmit queue. The host side does the reverse.

The block drives a receive trigger-reached level, which the interrupt logic uses. For each direction it also reports full, empty and an occupancy count. In FIFO mode each queue holds 16 bytes. In non-FIFO mode each queue behaves as a single holding register, and the trigger output reduces to a data-ready flag. Both queues are first-word-fall-through: the oldest byte is always visible on the data output.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset both queues are empty with a count of 0, rx_trig_o is 0, and the block is in non-FIFO mode (register value 0x00).
- R2: A register write with bit 0 = 1 selects FIFO mode, with 16 entries per queue. A write with bit 0 = 0 selects non-FIFO mode and clears the flush bits and the trigger code. Any write that changes bit 0 empties both queues at that write's clock edge.
- R3: If bit 0 was 0 before a write, bits 7:1 of that write are ignored. For example, writing 0x07 while disabled enables FIFO mode but flushes nothing and leaves trigger code 0.
- R4: Bit 1 (receive flush) empties the receive queue at the write's edge. While the bit stays 1, the receive queue stays empty and pushes into it are ignored, until a later write sets the bit to 0. The transmit queue is unaffected.
- R5: Bit 2 (transmit flush) acts in the same way on the transmit queue and leaves the receive queue unaffected.
- R6: Bits 7:5 hold the trigger code. Codes 0 to 7 give levels of 1, 2, 4, 6, 8, 10, 12 and 14 bytes. In FIFO mode rx_trig_o is 1 exactly while the receive count is at or above the level, and it drops in the same cycle that the count falls below the level.
- R7: Each queue returns bytes in push order. The count follows accepted pushes and pops. full_o is 1 at 16 entries and empty_o is 1 at 0 entries.
- R8: A push into a full queue is ignored, and a pop from an empty queue is ignored. A push and a pop in the same cycle are both accepted when the queue is neither full nor empty.
- R9: In non-FIFO mode each queue holds at most one byte and is full once that byte is held. rx_trig_o equals not rx_empty_o.
- R10: Bits 4:3 of the register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write data |
| rx_push_i | input | 1 | Push a received byte |
| rx_data_i | input | DATA_W | Received byte |
| rx_pop_i | input | 1 | Pop the oldest received byte |
| rx_data_o | output | DATA_W | Oldest received byte |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_count_o | output | CNT_W | Receive occupancy |
| rx_trig_o | output | 1 | Receive trigger level reached |
| tx_push_i | input | 1 | Push a byte to transmit |
| tx_data_i | input | DATA_W | Byte to transmit |
| tx_pop_i | input | 1 | Pop the oldest transmit byte |
| tx_data_o | output | DATA_W | Oldest transmit byte |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_count_o | output | CNT_W | Transmit occupancy |

## Verification
The assertions assume that the trigger code is only ever compared with a count that can reach 14, so they rely on the default depth of 16. They also assume that rst_ni is released only between clock edges. Inputs are driven away from the active edge. Register writes are sparse during the seeded random stream, bit 0 is held mostly set, and flush bits are set rarely, so the queues spend long stretches filling, draining and crossing every trigger level. Directed sequences cover the lock-out of bits written while disabled, mode changes with data held, sticky flushes, and pushes on a full queue or pops on an empty one.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  localparam int unsigned CFG_W = 8;

  // trigger code -> level: 0 gives 1, otherwise twice the code
  function automatic int unsigned trig_level(input logic [2:0] code);
    return (code == 3'd0) ? 1 : 2 * int'(code);
  endfunction

endpackage

// File: rtl/ufc_ctrl_reg.sv
module ufc_ctrl_reg
  import uart_fifo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic             fifo_en_o,
  output logic [2:0]       trig_code_o,
  output logic [1:0]       clr_o
);

  logic       en_q, rx_fl_q, tx_fl_q;
  logic [2:0] code_q;
  logic       mode_chg, load;

  logic unused_rsvd;
  assign unused_rsvd = ^wdata_i[4:3];

  assign mode_chg = we_i && (wdata_i[0] != en_q);
  assign load     = we_i && en_q && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      rx_fl_q <= 1'b0;
      tx_fl_q <= 1'b0;
      code_q  <= 3'd0;
    end else if (we_i) begin
      en_q <= wdata_i[0];
      if (load) begin
        rx_fl_q <= wdata_i[1];
        tx_fl_q <= wdata_i[2];
        code_q  <= wdata_i[7:5];
      end else if (en_q) begin
        rx_fl_q <= 1'b0;
        tx_fl_q <= 1'b0;
        code_q  <= 3'd0;
      end
    end
  end

  // flush takes effect at the write edge and holds while the bit is set
  assign clr_o[0] = rx_fl_q || mode_chg || (load && wdata_i[1]);
  assign clr_o[1] = tx_fl_q || mode_chg || (load && wdata_i[2]);

  assign fifo_en_o   = en_q;
  assign trig_code_o = code_q;

  // R3: fields stay cleared when written while disabled
  a_r3_locked_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !en_q |=> code_q == 3'd0 && !rx_fl_q && !tx_fl_q);

endmodule

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          single_i,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q, limit;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign limit   = single_i ? CW'(1) : CW'(DEPTH);
  assign full_o  = count_q >= limit;
  assign empty_o = count_q == '0;
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !clr_i) mem[wr_ptr_q] <= data_i;
  end

  assign data_o  = mem[rd_ptr_q];
  assign count_o = count_q;

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));

  a_r8_push_full_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !clr_i |=> $stable(count_o));

  // R4 and R5: a flush leaves the queue empty on the next cycle
  a_r4_clr_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);

  a_r9_single_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_i |-> count_q <= CW'(1));

endmodule

// File: rtl/ufc_trig.sv
module ufc_trig
  import uart_fifo_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic [CW-1:0] count_i,
  input  logic          fifo_en_i,
  input  logic [2:0]    code_i,
  output logic          trig_o
);

  logic [CW-1:0] level;

  assign level  = fifo_en_i ? CW'(trig_level(code_i)) : CW'(1);
  assign trig_o = count_i >= level;

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              rx_empty_o,
  output logic [CNT_W-1:0]  rx_count_o,
  output logic              rx_trig_o,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_full_o,
  output logic              tx_empty_o,
  output logic [CNT_W-1:0]  tx_count_o
);

  localparam int unsigned NDIR = 2; // 0 receive, 1 transmit

  logic                         fifo_en;
  logic [2:0]                   trig_code;
  logic [NDIR-1:0]              clr, push, pop, full, empty;
  logic [NDIR-1:0][DATA_W-1:0]  din, dout;
  logic [NDIR-1:0][CNT_W-1:0]   cnt;

  ufc_ctrl_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .wdata_i     (cfg_wdata_i),
    .fifo_en_o   (fifo_en),
    .trig_code_o (trig_code),
    .clr_o       (clr)
  );

  assign push = {tx_push_i, rx_push_i};
  assign pop  = {tx_pop_i, rx_pop_i};
  assign din  = {tx_data_i, rx_data_i};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    ufc_fifo #(
      .DW    (DATA_W),
      .DEPTH (DEPTH),
      .CW    (CNT_W)
    ) u_fifo (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .single_i (!fifo_en),
      .clr_i    (clr[d]),
      .push_i   (push[d]),
      .data_i   (din[d]),
      .pop_i    (pop[d]),
      .data_o   (dout[d]),
      .count_o  (cnt[d]),
      .full_o   (full[d]),
      .empty_o  (empty[d])
    );
  end

  ufc_trig #(.CW(CNT_W)) u_trig (
    .count_i   (cnt[0]),
    .fifo_en_i (fifo_en),
    .code_i    (trig_code),
    .trig_o    (rx_trig_o)
  );

  assign rx_data_o  = dout[0];
  assign rx_full_o  = full[0];
  assign rx_empty_o = empty[0];
  assign rx_count_o = cnt[0];
  assign tx_data_o  = dout[1];
  assign tx_full_o  = full[1];
  assign tx_empty_o = empty[1];
  assign tx_count_o = cnt[1];

  a_r9_trig_is_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en |-> rx_trig_o == !rx_empty_o);

  a_r6_trig_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_trig_o) && $stable(trig_code) && $stable(fifo_en)
      |-> rx_count_o < $past(rx_count_o));

endmodule

// File: tb/uart_fifo_ctrl_test.sv
module uart_fifo_ctrl_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic       rx_push_i = 1'b0, rx_pop_i = 1'b0, tx_push_i = 1'b0, tx_pop_i = 1'b0;
  logic [7:0] rx_data_i = '0, tx_data_i = '0;
  logic [7:0] rx_data_o, tx_data_o;
  logic       rx_full_o, rx_empty_o, rx_trig_o, tx_full_o, tx_empty_o;
  logic [4:0] rx_count_o, tx_count_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  bit         m_en = 0, m_rxfl = 0, m_txfl = 0;
  int         m_code = 0;

  uart_fifo_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .rx_push_i(rx_push_i), .rx_data_i(rx_data_i), .rx_pop_i(rx_pop_i),
    .rx_data_o(rx_data_o), .rx_full_o(rx_full_o), .rx_empty_o(rx_empty_o),
    .rx_count_o(rx_count_o), .rx_trig_o(rx_trig_o),
    .tx_push_i(tx_push_i), .tx_data_i(tx_data_i), .tx_pop_i(tx_pop_i),
    .tx_data_o(tx_data_o), .tx_full_o(tx_full_o), .tx_empty_o(tx_empty_o),
    .tx_count_o(tx_count_o)
  );

  always #10ns clk_i = ~clk_i;

  function automatic int level_of(int code);
    return (code == 0) ? 1 : 2 * code;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int cap;
    int lvl;
    cap = m_en ? 16 : 1;
    lvl = m_en ? level_of(m_code) : 1;
    chk(tag, "rx_count", int'(rx_count_o), rxq.size());
    chk(tag, "rx_empty", int'(rx_empty_o), int'(rxq.size() == 0));
    chk(tag, "rx_full", int'(rx_full_o), int'(rxq.size() >= cap));
    chk(tag, "rx_trig", int'(rx_trig_o), int'(rxq.size() >= lvl));
    chk(tag, "tx_count", int'(tx_count_o), txq.size());
    chk(tag, "tx_empty", int'(tx_empty_o), int'(txq.size() == 0));
    chk(tag, "tx_full", int'(tx_full_o), int'(txq.size() >= cap));
    if (rxq.size() > 0) chk(tag, "rx_data", int'(rx_data_o), int'(rxq[0]));
    if (txq.size() > 0) chk(tag, "tx_data", int'(tx_data_o), int'(txq[0]));
  endtask

  task automatic model_dir(inout logic [7:0] q[$], input bit clr, input bit psh,
                           input logic [7:0] d, input bit pp);
    int cap;
    bit pop_ok, push_ok;
    cap = m_en ? 16 : 1;
    if (clr) begin
      q.delete();
    end else begin
      pop_ok  = pp && (q.size() > 0);
      push_ok = psh && (q.size() < cap);
      if (pop_ok) void'(q.pop_front());
      if (push_ok) q.push_back(d);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic cyc(input string tag, input bit we, input logic [7:0] wd,
                     input bit rp, input logic [7:0] rd, input bit rpo,
                     input bit tp, input logic [7:0] td, input bit tpo);
    bit chg, rclr, tclr;
    cfg_we_i = we; cfg_wdata_i = wd;
    rx_push_i = rp; rx_data_i = rd; rx_pop_i = rpo;
    tx_push_i = tp; tx_data_i = td; tx_pop_i = tpo;
    @(posedge clk_i);
    chg  = we && (wd[0] != m_en);
    rclr = m_rxfl || chg || (we && m_en && wd[0] && wd[1]);
    tclr = m_txfl || chg || (we && m_en && wd[0] && wd[2]);
    model_dir(rxq, rclr, rp, rd, rpo);
    model_dir(txq, tclr, tp, td, tpo);
    if (we) begin
      if (m_en && wd[0]) begin
        m_rxfl = wd[1]; m_txfl = wd[2]; m_code = int'(wd[7:5]);
      end else if (m_en) begin
        m_rxfl = 0; m_txfl = 0; m_code = 0;
      end
      m_en = wd[0];
    end
    @(negedge clk_i);
    cfg_we_i = 1'b0; rx_push_i = 1'b0; rx_pop_i = 1'b0; tx_push_i = 1'b0; tx_pop_i = 1'b0;
    compare(tag);
  endtask

  task automatic wr(input string tag, input logic [7:0] v);
    cyc(tag, 1, v, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic rpush(input string tag, input logic [7:0] v);
    cyc(tag, 0, 0, 1, v, 0, 0, 0, 0);
  endtask
  task automatic rpop(input string tag);
    cyc(tag, 0, 0, 0, 0, 1, 0, 0, 0);
  endtask
  task automatic tpush(input string tag, input logic [7:0] v);
    cyc(tag, 0, 0, 0, 0, 0, 1, v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1");

    // R9: single holding register
    rpush("R9", 8'hA5);
    rpush("R9", 8'h5A);
    tpush("R9", 8'h3C);
    tpush("R9", 8'hC3);
    rpop("R9");
    rpop("R8");

    // R3: bits written while disabled are ignored
    wr("R3", 8'h07);
    for (int i = 0; i < 3; i++) rpush("R3", 8'(8'h10 + i));

    // R7, R8: fill, overflow, drain in order, underflow
    for (int i = 3; i < 16; i++) rpush("R7", 8'(8'h10 + i));
    rpush("R8", 8'hEE);
    cyc("R8", 0, 0, 1, 8'hDD, 1, 0, 0, 0);
    for (int i = 0; i < 16; i++) rpop("R7");
    rpop("R8");
    rpush("R8", 8'h77);
    cyc("R8", 0, 0, 1, 8'h78, 1, 0, 0, 0);
    rpop("R7");

    // R6: every trigger code, edge up and back down
    for (int c = 0; c < 8; c++) begin
      wr("R6", 8'h03);
      wr("R6", 8'((c << 5) | 1));
      for (int k = 0; k < level_of(c); k++) rpush("R6", 8'(c * 16 + k));
      rpop("R6");
      rpush("R6", 8'h99);
    end

    // R4: receive flush sticky, transmit untouched
    wr("R4", 8'h01);
    rpush("R4", 8'h01); rpush("R4", 8'h02);
    tpush("R4", 8'h81); tpush("R4", 8'h82);
    wr("R4", 8'h03);
    rpush("R4", 8'h03);
    rpush("R4", 8'h04);
    wr("R4", 8'h01);
    rpush("R4", 8'h05);

    // R5: transmit flush sticky, receive untouched
    wr("R5", 8'h05);
    tpush("R5", 8'h83);
    wr("R5", 8'h01);
    tpush("R5", 8'h84);

    // R10: reserved bits
    wr("R10", 8'h19);
    rpush("R10", 8'h06);
    wr("R10", 8'h59);

    // R2: disable with data held, then re-enable
    tpush("R2", 8'h85);
    wr("R2", 8'h00);
    rpush("R2", 8'h07);
    rpush("R2", 8'h08);
    wr("R2", 8'h01);
    for (int i = 0; i < 5; i++) tpush("R2", 8'(8'h90 + i));

    // R7: seeded random traffic
    for (int n = 0; n < 4000; n++) begin
      bit we;
      logic [7:0] wd;
      we = ($urandom % 40) == 0;
      wd = 8'($urandom);
      wd[0] = ($urandom % 10) != 0;
      wd[1] = ($urandom % 6) == 0;
      wd[2] = ($urandom % 6) == 0;
      cyc("R7", we, wd, ($urandom % 2) == 1, 8'($urandom), ($urandom % 5) < 2,
          ($urandom % 2) == 1, 8'($urandom), ($urandom % 5) < 2);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule